// File: doc/BRIEF.md
# SPI Bit-Clock Prescaler

This block turns the core clock into the timing for an SPI serial clock. A shift engine nearby uses its output to build the serial clock waveform. The block reads an 8-bit prescale field and decodes it into a divisor, using one of two encodings picked at build time. It then counts core-clock cycles and emits a one-cycle strobe at the end of each half period. Alongside the strobe, a phase flag shows whether the current half is the high half or the low half of the serial clock. Software computes the field from a target baud rate, so the block only decodes the field and divides.

The legacy encoding gives even divisors from 4 to 30. The extended encoding forms the divisor as a 4-bit mantissa shifted left by a 3-bit exponent, so it reaches 1920. The exponent bits are split across the field. Each transfer is begun by a start pulse and ended by a stop pulse. The divisor is captured only while no transfer is running, so it stays fixed for the whole transfer.

Top module: `spi_baud_presc`

## Requirements
- R1: Legacy format (FMT = FMT_LEGACY): the divisor is 2 × field[3:0]. Field bits 7:4 have no effect, so 0x10 + N gives 2N, and 0x1F gives the largest divisor, 30.
- R2: Legacy format: a decoded divisor below 4 (field[3:0] equal to 0 or 1) is replaced by 4.
- R3: Extended format (FMT = FMT_EXT): the mantissa is field[3:0] and the exponent is {field[7], field[6], field[4]}, with field[4] as the least significant exponent bit. The divisor is the mantissa shifted left by the exponent. field[5] has no effect. 0xDF gives 1920.
- R4: Extended format: a decoded divisor below 2 is replaced by 2.
- R5: During a transfer, the high half lasts ceil(D/2) core cycles and the low half lasts floor(D/2) core cycles, where D is the divisor. The halves alternate, and tog_o pulses for one cycle at the end of each half.
- R6: After the clock edge that samples start_i, phase_o is 1. The first tog_o appears in the cycle ceil(D/2) − 1 cycles after that edge.
- R7: A start_i pulse during a transfer restarts the half-period count and the high phase. The divisor is not reloaded.
- R8: div_o takes the decoded presc_i on every edge while no transfer is running. While a transfer runs, changes to presc_i have no effect on div_o until the edge after the stop.
- R9: Reset state: tog_o = 0, phase_o = 0, div_o = the format's minimum divisor (2 for extended, 4 for legacy).
- R10: After the edge that samples stop_i, tog_o stays 0 and phase_o is 0 until the next start. If start_i and stop_i arrive in the same cycle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| presc_i | input | 8 | Prescale field |
| start_i | input | 1 | Transfer start pulse (also restarts the count) |
| stop_i | input | 1 | Transfer end pulse |
| tog_o | output | 1 | One-cycle strobe at the end of each half period |
| phase_o | output | 1 | 1 during the high half, 0 during the low half and when idle |
| div_o | output | 11 | Divisor currently in effect |

## Verification
The clocked properties assume three things about the inputs:
- start_i and stop_i are single-cycle pulses.
- presc_i holds known values once reset is released.
- The half lengths seen by the timer change only while it is idle. The divisor register provides this, and a property checks it.

The bench drives every input on the falling clock edge and never holds a pulse for more than one cycle. It changes the field during a run only to show that the divisor stays frozen.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned SPR_W   = 4;
  localparam int unsigned SPPR_W  = 3;
  localparam int unsigned DIV_W   = SPR_W + (1 << SPPR_W) - 1;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [DIV_W-1:0]   div_t;
  typedef enum logic {FMT_LEGACY = 1'b0, FMT_EXT = 1'b1} fmt_e;
endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
  import spi_presc_pkg::*;
#(
  parameter fmt_e FMT = FMT_EXT
) (
  input  field_t field_i,
  output div_t   div_o
);
  localparam div_t MIN_DIV = (FMT == FMT_EXT) ? div_t'(2) : div_t'(4);

  div_t raw_div;

  generate
    if (FMT == FMT_EXT) begin : g_ext
      logic [SPR_W-1:0]  spr;
      logic [SPPR_W-1:0] sppr;
      logic              unused_bit5;
      assign spr         = field_i[3:0];
      // exponent lsb sits apart from its two upper bits
      assign sppr        = {field_i[7:6], field_i[4]};
      assign raw_div     = div_t'(spr) << sppr;
      assign unused_bit5 = field_i[5];
    end else begin : g_leg
      logic [3:0] unused_hi;
      assign raw_div   = div_t'({field_i[3:0], 1'b0});
      assign unused_hi = field_i[7:4];
    end
  endgenerate

  assign div_o = (raw_div < MIN_DIV) ? MIN_DIV : raw_div;
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer
  import spi_presc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  div_t hi_len_i,
  input  div_t lo_len_i,
  output logic tog_o,
  output logic phase_o,
  output logic run_o
);
  div_t cnt_q;
  logic run_q, phase_q;
  div_t cur_len;

  assign cur_len = phase_q ? hi_len_i : lo_len_i;
  assign tog_o   = run_q && (cnt_q == cur_len);
  assign phase_o = phase_q;
  assign run_o   = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      phase_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= div_t'(1);
      run_q   <= 1'b1;
      phase_q <= 1'b1;
    end else if (stop_i) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      phase_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == cur_len) begin
        cnt_q   <= div_t'(1);
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + div_t'(1);
      end
    end
  end

  a_r6_start_high_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (phase_q && cnt_q == div_t'(1) && run_q));

  a_r5_strobe_flips_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_o && !start_i && !stop_i) |=> (phase_q != $past(phase_q)));

  a_r5_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0 && cnt_q <= cur_len));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!tog_o && !phase_q));

  a_r10_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !run_q);
endmodule

// File: rtl/spi_baud_presc.sv
module spi_baud_presc
  import spi_presc_pkg::*;
#(
  parameter fmt_e FMT = FMT_EXT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] presc_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic               tog_o,
  output logic               phase_o,
  output logic [DIV_W-1:0]   div_o
);
  localparam div_t MIN_DIV = (FMT == FMT_EXT) ? div_t'(2) : div_t'(4);

  div_t dec_div, div_q, hi_len, lo_len;
  logic run;

  spi_presc_decode #(.FMT(FMT)) u_dec (
    .field_i (presc_i),
    .div_o   (dec_div)
  );

  // divisor frozen for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  div_q <= MIN_DIV;
    else if (!run) div_q <= dec_div;
  end

  assign lo_len = div_q >> 1;
  assign hi_len = div_q - lo_len;

  spi_half_timer u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .hi_len_i (hi_len),
    .lo_len_i (lo_len),
    .tog_o    (tog_o),
    .phase_o  (phase_o),
    .run_o    (run)
  );

  assign div_o = div_q;

  a_r8_div_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> $stable(div_q));

  a_r4_div_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q >= MIN_DIV);

  a_r8_idle_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (div_q == $past(dec_div)));
endmodule

// File: tb/sim_spi_baud_presc.sv
module sim_spi_baud_presc;
  import spi_presc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] presc = 8'h00;
  logic start = 1'b0, stop = 1'b0;
  logic tog0, ph0, tog1, ph1;
  logic [DIV_W-1:0] div0, div1;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  spi_baud_presc #(.FMT(FMT_EXT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .presc_i(presc), .start_i(start), .stop_i(stop),
    .tog_o(tog0), .phase_o(ph0), .div_o(div0));

  spi_baud_presc #(.FMT(FMT_LEGACY)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .presc_i(presc), .start_i(start), .stop_i(stop),
    .tog_o(tog1), .phase_o(ph1), .div_o(div1));

  // {field, expected divisor}
  localparam logic [18:0] EXT_TBL [11] = '{
    {8'h00, 11'd2},  {8'h01, 11'd2},  {8'h03, 11'd3},  {8'h0F, 11'd15},
    {8'h10, 11'd2},  {8'h13, 11'd6},  {8'h45, 11'd20}, {8'h85, 11'd80},
    {8'hDF, 11'd1920}, {8'h2A, 11'd10}, {8'h09, 11'd9}};
  localparam logic [18:0] LEG_TBL [7] = '{
    {8'h10, 11'd4}, {8'h11, 11'd4}, {8'h12, 11'd4}, {8'h15, 11'd10},
    {8'h1F, 11'd30}, {8'h07, 11'd14}, {8'hE3, 11'd6}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sel_tog(input logic s);
    return s ? tog1 : tog0;
  endfunction

  // start, then record index of first three strobes after the start edge
  task automatic measure(input logic s, output int p0, output int p1, output int p2,
                         output logic phase_at0);
    int n = 0;
    int q [3] = '{-1, -1, -1};
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    phase_at0 = s ? ph1 : ph0;
    for (int j = 0; j < 6000 && n < 3; j++) begin
      if (sel_tog(s)) begin q[n] = j; n++; end
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    p0 = q[0]; p1 = q[1]; p2 = q[2];
  endtask

  task automatic timing(input string req, input logic s, input logic [7:0] f,
                        input int e0, input int e1, input int e2);
    int a0, a1, a2;
    logic pz;
    presc = f;
    @(negedge clk);
    measure(s, a0, a1, a2, pz);
    chk({req, " first strobe"}, a0, e0);
    chk({req, " second strobe"}, a1, e1);
    chk({req, " third strobe"}, a2, e2);
    chk("R6 phase high after start", int'(pz), 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int first;
    int cnt;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ext div reset", int'(div0), 2);
    chk("R9 legacy div reset", int'(div1), 4);
    chk("R9 tog reset", int'(tog0 | tog1), 0);
    chk("R9 phase reset", int'(ph0 | ph1), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      presc = EXT_TBL[i][18:11];
      @(negedge clk);
      chk("R3/R4 extended decode", int'(div0), int'(EXT_TBL[i][10:0]));
    end
    for (int i = 0; i < 7; i++) begin
      presc = LEG_TBL[i][18:11];
      @(negedge clk);
      chk("R1/R2 legacy decode", int'(div1), int'(LEG_TBL[i][10:0]));
    end

    // R5 / R6 half-period timing
    timing("R5 ext d2", 1'b0, 8'h00, 0, 1, 2);
    timing("R5 ext d3 odd", 1'b0, 8'h03, 1, 2, 4);
    timing("R5 ext d6", 1'b0, 8'h13, 2, 5, 8);
    timing("R5 ext d9 odd", 1'b0, 8'h09, 4, 8, 13);
    timing("R5 ext d1920", 1'b0, 8'hDF, 959, 1919, 2879);
    timing("R5 legacy d10", 1'b1, 8'h15, 4, 9, 14);
    timing("R2 legacy clamp d4", 1'b1, 8'h00, 1, 3, 5);

    // R7 restart during a run (d=6, half=3)
    presc = 8'h13;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 phase high after restart", int'(ph0), 1);
    first = -1;
    for (int j = 0; j < 20 && first < 0; j++) begin
      if (tog0) first = j;
      else @(negedge clk);
    end
    chk("R7 first strobe after restart", first, 2);
    chk("R7 divisor kept", int'(div0), 6);

    // R8 field change while running is ignored
    presc = 8'hDF;
    repeat (5) @(negedge clk);
    chk("R8 div frozen in run", int'(div0), 6);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 div at stop edge", int'(div0), 6);
    @(negedge clk);
    chk("R8 div reloads when idle", int'(div0), 1920);

    // R10 quiet after stop, start beats stop
    cnt = 0;
    for (int j = 0; j < 50; j++) begin
      if (tog0 || ph0) cnt++;
      @(negedge clk);
    end
    chk("R10 idle quiet", cnt, 0);
    presc = 8'h00;
    @(negedge clk);
    start = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    chk("R10 start wins over stop", int'(ph0 & tog0), 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R10 stopped", int'(ph0 | tog0), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule